// File: doc/BRIEF.md
# Timing Diagnostic Error Latch

This block watches the health of a clock-distribution path and keeps a sticky record of any fault it sees. Three activity monitors run from the system clock. One watches the selected timing source and the other two watch the 3600 Hz and 4800 Hz tones produced for the transition encoders. A monitor reports its signal as stale when the signal has not changed level for a programmable number of clock cycles. Two further error inputs come from the detectors that check the positive and negative legs of the timing output driver.

The five error conditions are ORed into a composite. The composite sets a fault latch that drives `refFault`. The source monitor also sets a separate loss latch that drives `lossFault`, so a short dropout of the source is still visible later. An operator clear pulse returns both latches and all monitors to the no-error state. A self-test input forces both fault outputs high for as long as it is held. When self-test is released, the outputs show the latched state again.

Top module: `timing_diag_latch`

## Requirements
- R1: Each monitor counts clock cycles since it last sampled a change of level (either direction) on its watched signal, and reports stale once the count reaches its limit input (limit at least 1). If the last change is sampled at clock edge k, the matching fault output first reads high after edge k+limit+1.
- R2: When the source monitor goes stale, `lossFault` and `refFault` are set on the next clock. `lossFault` stays set after the source recovers.
- R3: A high level on `driveErrP` or `driveErrN` at a clock edge sets `refFault` from that edge onward. It does not set `lossFault`.
- R4: Once set, `refFault` stays high with no clear pulse, even after every error source has gone inactive.
- R5: A rising edge of `panelClear` clears both latches at the next clock and restarts all three monitors. Holding `panelClear` high acts only once, so an error during the hold sets the latch again and it stays set.
- R6: If a clear edge and an active error source fall in the same cycle, the error wins and `refFault` stays set.
- R7: While `selfTest` is high, `lossFault` and `refFault` are both high in the same cycle, whatever the latched state.
- R8: When `selfTest` goes low, each output returns to its own latched value.
- R9: A stale 3600 Hz or 4800 Hz tone monitor sets `refFault` but not `lossFault`.
- R10: After `rstN` is released, both fault outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTiming | input | 1 | Selected timing source, sampled level |
| tone3600 | input | 1 | 3600 Hz encoder tone, sampled level |
| tone4800 | input | 1 | 4800 Hz encoder tone, sampled level |
| driveErrP | input | 1 | Error from the positive timing-output leg detector |
| driveErrN | input | 1 | Error from the negative timing-output leg detector |
| srcLimit | input | CNT_W | Quiet-cycle limit for the source monitor |
| limit3600 | input | CNT_W | Quiet-cycle limit for the 3600 Hz monitor |
| limit4800 | input | CNT_W | Quiet-cycle limit for the 4800 Hz monitor |
| panelClear | input | 1 | Operator clear; its rising edge acts |
| selfTest | input | 1 | Forces both fault outputs high |
| lossFault | output | 1 | Latched loss of timing source |
| refFault | output | 1 | Latched composite fault |

## Verification
The assertions check on every cycle that:
- an active error source sets the composite latch on the next clock;
- the latch holds when no clear pulse arrives;
- a clear with no error present empties both latches;
- a clear that coincides with an error leaves the latch set;
- a change on a watched signal removes staleness;
- self-test forces both outputs high.

Only the bench scenarios show the exact number of quiet cycles before a fault appears, for each monitor across a sweep of limits up to the counter's maximum. The same applies to the outputs returning to their latched values when self-test is released, to a held clear acting only once, and to `lossFault` staying low for tone or driver faults.

// File: rtl/timing_diag_pkg.sv
package timing_diag_pkg;
  // Index of each activity monitor inside the datapath vectors.
  localparam int MON_SRC  = 0;
  localparam int MON_3600 = 1;
  localparam int MON_4800 = 2;
  localparam int NUM_MON  = 3;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic clearPulse;  // one-cycle clear, taken from the rising edge of the panel input
    logic forceErr;    // self-test override
  } diagStrobes_t;
endpackage

// File: rtl/activity_watch.sv
module activity_watch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             watchSig,
  input  logic [CNT_W-1:0] limit,
  input  logic             restart,
  output logic             stale
);
  logic             prevSig;
  logic [CNT_W-1:0] quietCnt;
  logic             edgeSeen;

  assign edgeSeen = watchSig ^ prevSig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSig  <= 1'b0;
      quietCnt <= '0;
    end else begin
      prevSig <= watchSig;
      if (edgeSeen || restart) begin
        quietCnt <= '0;
      end else if (quietCnt < limit) begin
        quietCnt <= quietCnt + 1'b1;
      end
    end
  end

  assign stale = (quietCnt >= limit);

  // R1: a sampled change or a restart leaves the monitor not stale on the next cycle.
  assert_edge_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen || restart) |=> (!stale || limit == '0));
endmodule

// File: rtl/diag_ctrl.sv
module diag_ctrl
  import timing_diag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         panelClear,
  input  logic         selfTest,
  output diagStrobes_t strobes
);
  logic panelPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) panelPrev <= 1'b0;
    else       panelPrev <= panelClear;
  end

  always_comb begin
    strobes.clearPulse = panelClear & ~panelPrev;
    strobes.forceErr   = selfTest;
  end

  // R5: a held clear produces a single pulse.
  assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearPulse |=> !strobes.clearPulse);
endmodule

// File: rtl/diag_datapath.sv
module diag_datapath
  import timing_diag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTiming,
  input  logic             tone3600,
  input  logic             tone4800,
  input  logic             driveErrP,
  input  logic             driveErrN,
  input  logic [CNT_W-1:0] srcLimit,
  input  logic [CNT_W-1:0] limit3600,
  input  logic [CNT_W-1:0] limit4800,
  input  diagStrobes_t     strobes,
  output logic             lossFault,
  output logic             refFault
);
  logic [NUM_MON-1:0]            watchVec;
  logic [NUM_MON-1:0][CNT_W-1:0] limitVec;
  logic [NUM_MON-1:0]            staleVec;
  logic                          anyErr;
  logic                          lossLatch;
  logic                          refLatch;

  always_comb begin
    watchVec[MON_SRC]  = srcTiming;
    watchVec[MON_3600] = tone3600;
    watchVec[MON_4800] = tone4800;
    limitVec[MON_SRC]  = srcLimit;
    limitVec[MON_3600] = limit3600;
    limitVec[MON_4800] = limit4800;
  end

  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    activity_watch #(.CNT_W(CNT_W)) i_watch (
      .clk     (clk),
      .rstN    (rstN),
      .watchSig(watchVec[m]),
      .limit   (limitVec[m]),
      .restart (strobes.clearPulse),
      .stale   (staleVec[m])
    );
  end

  assign anyErr = (|staleVec) | driveErrP | driveErrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossLatch <= 1'b0;
      refLatch  <= 1'b0;
    end else begin
      if (staleVec[MON_SRC])       lossLatch <= 1'b1;
      else if (strobes.clearPulse) lossLatch <= 1'b0;
      if (anyErr)                  refLatch  <= 1'b1;
      else if (strobes.clearPulse) refLatch  <= 1'b0;
    end
  end

  assign lossFault = lossLatch | strobes.forceErr;
  assign refFault  = refLatch  | strobes.forceErr;

  // R2: a stale source sets the loss latch.
  assert_loss_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    staleVec[MON_SRC] |=> lossLatch);
  // R3: any error source sets the composite latch.
  assert_any_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> refLatch);
  // R4: the latch is sticky with no clear.
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (refLatch && !strobes.clearPulse) |=> refLatch);
  // R5: a clear with no error present empties both latches.
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearPulse && !anyErr) |=> (!refLatch && !lossLatch));
  // R6: an error wins over a coincident clear.
  assert_err_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearPulse && anyErr) |=> refLatch);
  // R7: self-test forces both outputs.
  assert_force_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceErr |-> (lossFault && refFault));
endmodule

// File: rtl/timing_diag_latch.sv
module timing_diag_latch
  import timing_diag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTiming,
  input  logic             tone3600,
  input  logic             tone4800,
  input  logic             driveErrP,
  input  logic             driveErrN,
  input  logic [CNT_W-1:0] srcLimit,
  input  logic [CNT_W-1:0] limit3600,
  input  logic [CNT_W-1:0] limit4800,
  input  logic             panelClear,
  input  logic             selfTest,
  output logic             lossFault,
  output logic             refFault
);
  diagStrobes_t strobes;

  diag_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .panelClear(panelClear),
    .selfTest  (selfTest),
    .strobes   (strobes)
  );

  diag_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcTiming(srcTiming),
    .tone3600 (tone3600),
    .tone4800 (tone4800),
    .driveErrP(driveErrP),
    .driveErrN(driveErrN),
    .srcLimit (srcLimit),
    .limit3600(limit3600),
    .limit4800(limit4800),
    .strobes  (strobes),
    .lossFault(lossFault),
    .refFault (refFault)
  );
endmodule

// File: tb/test_timing_diag_latch.sv
module test_timing_diag_latch;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int MAX_LIM = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] sigs = '0;
  logic [2:0] run = '0;
  logic driveErrP = 1'b0, driveErrN = 1'b0;
  logic [CNT_W-1:0] lim0 = 4'd2, lim1 = 4'd2, lim2 = 4'd2;
  logic panelClear = 1'b0, selfTest = 1'b0;
  logic lossFault, refFault;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timing_diag_latch #(.CNT_W(CNT_W)) i_timing_diag_latch (
    .clk(clk), .rstN(rstN),
    .srcTiming(sigs[0]), .tone3600(sigs[1]), .tone4800(sigs[2]),
    .driveErrP(driveErrP), .driveErrN(driveErrN),
    .srcLimit(lim0), .limit3600(lim1), .limit4800(lim2),
    .panelClear(panelClear), .selfTest(selfTest),
    .lossFault(lossFault), .refFault(refFault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits past a rising edge, then toggles every running monitor input.
  task automatic step();
    @(posedge clk);
    #2;
    for (int m = 0; m < 3; m++) if (run[m]) sigs[m] = ~sigs[m];
  endtask

  task automatic clearAll();
    run = 3'b111;
    repeat (3) step();
    panelClear = 1'b1;
    step();
    panelClear = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    // R10: reset state
    check(refFault == 0 && lossFault == 0, "R10 reset", {lossFault, refFault}, 0);
    rstN = 1'b1;
    step();
    check(refFault == 0 && lossFault == 0, "R10 after release", {lossFault, refFault}, 0);

    // R1, R2, R9: sweep limits for each monitor
    for (int lim = 1; lim <= MAX_LIM; lim++) begin
      for (int m = 0; m < 3; m++) begin
        int firstJ;
        lim0 = lim[CNT_W-1:0]; lim1 = lim[CNT_W-1:0]; lim2 = lim[CNT_W-1:0];
        clearAll();
        check(refFault == 0 && lossFault == 0, "R5 clear", {lossFault, refFault}, 0);
        run[m] = 1'b0;
        firstJ = 0;
        for (int j = 1; j <= 20; j++) begin
          step();
          if (firstJ == 0 && refFault) firstJ = j;
        end
        check(firstJ == lim + 2, "R1 quiet cycles to fault", firstJ, lim + 2);
        if (m == 0) check(lossFault == 1, "R2 loss set", lossFault, 1);
        else        check(lossFault == 0, "R9 tone no loss", lossFault, 0);
      end
    end

    // R2: loss stays after recovery
    lim0 = 4'd3; lim1 = 4'd3; lim2 = 4'd3;
    clearAll();
    run[0] = 1'b0;
    repeat (8) step();
    run[0] = 1'b1;
    repeat (6) step();
    check(lossFault == 1, "R2 loss sticky after recovery", lossFault, 1);

    // R3, R4: driver error pulses
    for (int k = 0; k < 2; k++) begin
      clearAll();
      if (k == 0) driveErrP = 1'b1; else driveErrN = 1'b1;
      step();
      driveErrP = 1'b0; driveErrN = 1'b0;
      check(refFault == 1, "R3 driver error sets", refFault, 1);
      check(lossFault == 0, "R3 driver error no loss", lossFault, 0);
      repeat (5) step();
      check(refFault == 1, "R4 sticky", refFault, 1);
    end

    // R6: error and clear edge in the same cycle
    clearAll();
    driveErrP = 1'b1;
    panelClear = 1'b1;
    step();
    check(refFault == 1, "R6 error wins", refFault, 1);
    driveErrP = 1'b0;
    // R5: held clear acts once
    step();
    driveErrN = 1'b1;
    step();
    driveErrN = 1'b0;
    repeat (3) step();
    check(refFault == 1, "R5 held clear acts once", refFault, 1);
    panelClear = 1'b0;
    step();

    // R7, R8: self-test with clear latches
    clearAll();
    selfTest = 1'b1;
    #1;
    check(refFault == 1 && lossFault == 1, "R7 force", {lossFault, refFault}, 3);
    step();
    check(refFault == 1 && lossFault == 1, "R7 force held", {lossFault, refFault}, 3);
    selfTest = 1'b0;
    #1;
    check(refFault == 0 && lossFault == 0, "R8 release clear", {lossFault, refFault}, 0);
    // R8: release with only the composite latched
    driveErrP = 1'b1;
    step();
    driveErrP = 1'b0;
    selfTest = 1'b1;
    step();
    selfTest = 1'b0;
    #1;
    check(refFault == 1 && lossFault == 0, "R8 release latched", {lossFault, refFault}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule